// File: doc/BRIEF.md
# Interleaved Memory Target Selector

This block takes a host physical address that falls in a fixed memory window and returns the index of the host-bridge target that owns that address. The window's addresses are spread across 1, 2, 3, 4, 6, 8, 12 or 16 targets at a programmable granularity. Each request is a strobe plus an address. The static configuration holds the arithmetic mode, the encoded way count, the encoded granularity, the window base and size, and four XOR map words. The result comes out one clock later as a valid strobe with a target index, a hit flag and an error flag.

Two selection rules exist. Modulo selection rotates through the targets one granule at a time. XOR selection builds each index bit from the parity of the address under one map word. For 3, 6 and 12 ways it also places a remainder modulo 3 of the upper address bits above the parity bits. Every remainder is computed by summing base-4 digits, so no divider is used.

Top module: `xor_target_sel`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high, and low otherwise. The index and flags belong to the address presented in that earlier cycle.
- R2: When `cfg_eiw` = 0 (one way), a hit always yields index 0 in both modes. The programmed granularity is then ignored, so even `cfg_eig` = 7 raises no error.
- R3: Modulo mode (`cfg_mode` = 0) with 2, 4, 8 or 16 ways returns (addr >> (8 + `cfg_eig`)) mod ways.
- R4: Modulo mode with 3, 6 or 12 ways also returns (addr >> (8 + `cfg_eig`)) mod ways.
- R5: XOR mode (`cfg_mode` = 1) with 2^p ways sets index bit i, for i < p, to the parity of addr AND map i. Map i is `cfg_xmap[i*AW +: AW]`.
- R6: XOR mode with `cfg_eiw` codes 8, 9 and 10 (3, 6 and 12 ways) uses p = `cfg_eiw` - 8 parity bits as in R5, so 3 ways uses no map. Above them it places ((addr with bits below `cfg_eiw` + `cfg_eig` cleared) mod 3).
- R7: `cfg_mode` values 2 and 3 are illegal and raise `out_err`.
- R8: Way codes are `cfg_eiw` 0 to 4 for 1, 2, 4, 8 and 16 ways, and 8 to 10 for 3, 6 and 12 ways. Any other code raises `out_err` and gives index 0.
- R9: The granularity is 256 << `cfg_eig` bytes. When there is more than one way, `cfg_eig` = 7 raises `out_err`.
- R10: If bits 27:0 of `cfg_base` or of `cfg_size` are nonzero (not 256 MB aligned), `out_err` is raised.
- R11: `out_hit` is high only if base <= addr <= base + size - 1 and there is no error. On a miss or an error, `out_target` is 0.
- R12: After reset, `out_valid`, `out_hit`, `out_err` and `out_target` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | AW | Host physical address |
| cfg_mode | input | 2 | 0 modulo, 1 XOR, others illegal |
| cfg_eiw | input | 4 | Encoded way count |
| cfg_eig | input | 3 | Encoded granularity |
| cfg_base | input | AW | Window base address |
| cfg_size | input | AW | Window size in bytes |
| cfg_xmap | input | 4*AW | XOR map words, map i at bits i*AW upward |
| out_valid | output | 1 | Result strobe |
| out_target | output | 4 | Selected target index |
| out_hit | output | 1 | Address inside a valid window |
| out_err | output | 1 | Configuration error |

## Verification
The assertions take the configuration as static for the cycle in which a request is captured. They also take the window size to be nonzero, because an empty window would make "no hit" hold vacuously. The stimulus changes configuration only after every outstanding result has been compared and the pipeline has been idle for a cycle. It also keeps all window sizes nonzero and every address well inside the 52-bit space.

// File: rtl/xor_target_sel.sv
module xor_target_sel #(
  parameter int AW = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_addr,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_eiw,
  input  logic [2:0]       cfg_eig,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_size,
  input  logic [4*AW-1:0]  cfg_xmap,
  output logic             out_valid,
  output logic [3:0]       out_target,
  output logic             out_hit,
  output logic             out_err
);
  localparam int NM    = 4;
  localparam int TW    = 4;
  localparam int ALIGN = 28;
  localparam int DW    = (AW + 1) / 2;

  function automatic logic [1:0] mod3(input logic [AW-1:0] v);
    logic [2*DW-1:0] w;
    logic [7:0]      acc;
    w   = (2*DW)'(v);
    acc = '0;
    for (int j = 0; j < DW; j++) acc = acc + 8'(w[2*j +: 2]);
    acc = 8'(acc[1:0]) + 8'(acc[3:2]) + 8'(acc[5:4]) + 8'(acc[7:6]);
    acc = 8'(acc[1:0]) + 8'(acc[3:2]) + 8'(acc[5:4]) + 8'(acc[7:6]);
    return 2'(acc >= 8'd6 ? acc - 8'd6 : acc >= 8'd3 ? acc - 8'd3 : acc);
  endfunction

  logic          x3, one_way, ways_ok, cfg_err, in_win;
  logic [2:0]    p;
  logic [4:0]    gs;
  logic [AW-1:0] s, xmask;
  logic [TW-1:0] lowmask, par, tgt_mod, tgt_xor, tgt;
  logic [1:0]    m3_mod, m3_xor;

  assign x3      = (cfg_eiw == 4'd8) || (cfg_eiw == 4'd9) || (cfg_eiw == 4'd10);
  assign one_way = (cfg_eiw == 4'd0);
  assign ways_ok = (cfg_eiw <= 4'd4) || x3;
  assign p       = x3 ? 3'(cfg_eiw - 4'd8) : 3'(cfg_eiw);
  assign gs      = one_way ? 5'd8 : 5'd8 + 5'(cfg_eig);

  assign cfg_err = (cfg_mode > 2'd1) || !ways_ok || (!one_way && cfg_eig == 3'd7)
                 || (|cfg_base[ALIGN-1:0]) || (|cfg_size[ALIGN-1:0]);

  assign in_win  = (in_addr >= cfg_base)
                 && (({1'b0, in_addr} - {1'b0, cfg_base}) < {1'b0, cfg_size});

  assign s       = in_addr >> gs;
  assign lowmask = 4'((5'd1 << p) - 5'd1);
  assign m3_mod  = mod3(s >> p);
  assign xmask   = ~((AW'(1) << (5'(cfg_eiw) + 5'(cfg_eig))) - AW'(1));
  assign m3_xor  = mod3(in_addr & xmask);

  for (genvar i = 0; i < NM; i++) begin : g_par
    assign par[i] = ^(in_addr & cfg_xmap[i*AW +: AW]);
  end

  assign tgt_mod = (TW'(s) & lowmask) | (x3 ? TW'(m3_mod) << p : '0);
  assign tgt_xor = (par & lowmask)    | (x3 ? TW'(m3_xor) << p : '0);
  assign tgt     = one_way ? '0 : (cfg_mode == 2'd0) ? tgt_mod : tgt_xor;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_target <= '0;
      out_hit    <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err    <= cfg_err;
        out_hit    <= in_win && !cfg_err;
        out_target <= (in_win && !cfg_err) ? tgt : '0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_ONE_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit && $past(cfg_eiw) == 4'd0 |-> out_target == '0); // R2
  AST_THREE_WAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit && $past(cfg_eiw) == 4'd8 |-> out_target < 4'd3); // R6
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(cfg_mode) > 2'd1 |-> out_err); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_hit && out_target == '0); // R11
endmodule

// File: tb/xor_target_sel_bench.sv
module xor_target_sel_bench;
  localparam int AW = 52;

  typedef struct {
    logic       hit;
    logic       err;
    logic [3:0] tgt;
    string      tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [AW-1:0]   in_addr = '0;
  logic [1:0]      cfg_mode = '0;
  logic [3:0]      cfg_eiw = '0;
  logic [2:0]      cfg_eig = '0;
  logic [AW-1:0]   cfg_base = '0;
  logic [AW-1:0]   cfg_size = '0;
  logic [4*AW-1:0] cfg_xmap = '0;
  logic            out_valid, out_hit, out_err;
  logic [3:0]      out_target;

  int   n_checks = 0, n_fail = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  xor_target_sel #(.AW(AW)) u_xor_target_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_mode(cfg_mode), .cfg_eiw(cfg_eiw), .cfg_eig(cfg_eig),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_xmap(cfg_xmap),
    .out_valid(out_valid), .out_target(out_target), .out_hit(out_hit), .out_err(out_err));

  function automatic exp_t model(input logic [63:0] a, input string tag);
    exp_t e;
    logic [63:0] base, size, m, v;
    int ways, p, gs, sh;
    logic bad;
    base = 64'(cfg_base); size = 64'(cfg_size);
    bad = (cfg_mode > 1) || !(cfg_eiw <= 4 || (cfg_eiw >= 8 && cfg_eiw <= 10))
        || (cfg_eiw != 0 && cfg_eig == 7) || (base % 64'h1000_0000 != 0)
        || (size % 64'h1000_0000 != 0);
    e.err = bad; e.tag = tag; e.tgt = 0;
    e.hit = !bad && a >= base && a <= base + size - 1;
    if (e.hit && cfg_eiw != 0) begin
      ways = (cfg_eiw <= 4) ? (1 << cfg_eiw) : (3 << (cfg_eiw - 8));
      p    = (cfg_eiw <= 4) ? int'(cfg_eiw) : int'(cfg_eiw) - 8;
      gs   = 8 + int'(cfg_eig);
      if (cfg_mode == 0) e.tgt = 4'((a >> gs) % 64'(ways));
      else begin
        for (int i = 0; i < p; i++) begin
          m = 64'(cfg_xmap[i*AW +: AW]);
          e.tgt[i] = $countones(a & m) % 2 == 1;
        end
        if (cfg_eiw >= 8) begin
          sh = int'(cfg_eiw) + int'(cfg_eig);
          v  = (a >> sh) << sh;
          e.tgt = e.tgt + 4'((v % 3) << p);
        end
      end
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] a, input string tag);
    @(negedge clk);
    in_addr  = AW'(a);
    in_valid = 1'b1;
    q.push_back(model(a, tag));
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle out_valid actual=%b expected=0", out_valid);
    end
  endtask

  task automatic setup(input logic [1:0] md, input logic [3:0] w, input logic [2:0] g,
                       input logic [63:0] b, input logic [63:0] sz);
    cfg_mode = md; cfg_eiw = w; cfg_eig = g; cfg_base = AW'(b); cfg_size = AW'(sz);
  endtask

  task automatic sweep(input int n, input logic [63:0] salt, input string tag);
    for (int k = 0; k < n; k++)
      send(64'(cfg_base) + ((64'(k) * salt) % 64'(cfg_size)), tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_checks++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_hit !== e.hit || out_err !== e.err || out_target !== e.tgt) begin
          n_fail++;
          $display("FAIL %s actual hit=%b err=%b tgt=%0d expected hit=%b err=%b tgt=%0d",
                   e.tag, out_hit, out_err, out_target, e.hit, e.err, e.tgt);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++)
      cfg_xmap[i*AW +: AW] = AW'((64'd1 << (8 + i)) | (64'd1 << (13 + i)) |
                                 (64'd1 << (20 + 2*i)) | (64'd1 << (31 + i)));
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || out_hit !== 0 || out_err !== 0 || out_target !== 0) begin
      n_fail++;
      $display("FAIL R12 reset actual v=%b h=%b e=%b t=%0d expected all 0",
               out_valid, out_hit, out_err, out_target);
    end
    rst_n = 1'b1;

    setup(0, 2, 0, 64'h1_0000_0000, 64'h4000_0000);
    for (int k = 0; k < 12; k++) send(64'h1_0000_0000 + 64'(k) * 256, "R3");
    sweep(20, 64'h0012_3457_9ABD, "R3");
    drain();
    setup(0, 3, 2, 64'h1_0000_0000, 64'h4000_0000); sweep(20, 64'h0003_1415_9265, "R3"); drain();
    setup(0, 4, 5, 64'h2_0000_0000, 64'h1_0000_0000); sweep(20, 64'h0007_7777_1234, "R3"); drain();

    for (int w = 8; w <= 10; w++) begin
      setup(0, 4'(w), 3'(w - 8), 64'h1_0000_0000, 64'h4000_0000);
      for (int k = 0; k < 14; k++) send(64'h1_0000_0000 + 64'(k) * (64'd256 << (w - 8)), "R4");
      sweep(20, 64'h0002_7182_8183, "R4");
      drain();
    end

    setup(0, 0, 7, 64'h1_0000_0000, 64'h4000_0000); sweep(10, 64'h0001_2345_6789, "R2"); drain();
    setup(1, 0, 7, 64'h1_0000_0000, 64'h4000_0000); sweep(10, 64'h0005_4321_0FED, "R2"); drain();

    for (int w = 1; w <= 4; w++) begin
      setup(1, 4'(w), 3'(w), 64'h3_0000_0000, 64'h2000_0000);
      sweep(24, 64'h0009_E377_9B97, "R5");
      drain();
    end

    for (int w = 8; w <= 10; w++) begin
      setup(1, 4'(w), 3'(11 - w), 64'h1_0000_0000, 64'h4000_0000);
      sweep(24, 64'h000B_5297_A4D3, "R6");
      drain();
    end

    setup(2, 2, 0, 64'h1_0000_0000, 64'h4000_0000); sweep(4, 64'h0001_0001, "R7"); drain();
    setup(3, 2, 0, 64'h1_0000_0000, 64'h4000_0000); sweep(4, 64'h0001_0001, "R7"); drain();

    setup(0, 5, 0, 64'h1_0000_0000, 64'h4000_0000); sweep(4, 64'h0001_0101, "R8"); drain();
    setup(1, 11, 0, 64'h1_0000_0000, 64'h4000_0000); sweep(4, 64'h0001_0101, "R8"); drain();

    setup(0, 2, 7, 64'h1_0000_0000, 64'h4000_0000); sweep(4, 64'h0001_0303, "R9"); drain();

    setup(0, 2, 0, 64'h1_0010_0000, 64'h4000_0000); sweep(4, 64'h0001_0505, "R10"); drain();
    setup(0, 2, 0, 64'h1_0000_0000, 64'h4008_0000); sweep(4, 64'h0001_0505, "R10"); drain();

    setup(0, 2, 0, 64'h1_0000_0000, 64'h4000_0000);
    send(64'h0_FFFF_FFFF, "R11");
    send(64'h1_0000_0000, "R11");
    send(64'h1_3FFF_FFFF, "R11");
    send(64'h1_4000_0000, "R11");
    send(64'h0_0000_0100, "R11");
    drain();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule